// File: doc/BRIEF.md
# Iterative Multiply Divide Unit

This block is an unsigned arithmetic unit that computes either a product or a quotient/remainder pair one bit at a time. It does not advance on its own. Each step is taken only in a clock cycle where the step input is high. Between steps the partial result stays visible on the result outputs. A multiply takes eight steps and a divide takes sixteen. Both operations share the same two result registers and one internal shift register, so only one operation can be in flight at a time.

A start strobe loads the operands and arms the step counter. Start-multiply loads an 8-bit multiplicand and an 8-bit multiplier. Start-divide loads a 16-bit dividend and an 8-bit divisor. The divisor comes in on the same input as the multiplicand. On each step a multiply does one shift-and-add, and a divide does one restoring compare-and-subtract.

Control is a three-state machine:
- IDLE means no operation is armed.
- MUL means a multiply is counting down.
- DIV means a divide is counting down.

Transitions:
- IDLE→MUL on a start-multiply.
- IDLE→DIV on a start-divide.
- MUL→IDLE or DIV→IDLE on the step that brings the counter from 1 to 0.
- MUL→DIV, DIV→MUL, MUL→MUL and DIV→DIV when a new start arrives while busy. This restart discards the operation in progress.

Top module: `muldiv_iter`

## Requirements
- R1: After reset `busy_o` is 0, and `prodrem_o` and `quot_o` are 0.
- R2: A start-multiply with no start-divide in the same cycle loads the multiplier, zero-extended, into `quot_o` and clears `prodrem_o`, both visible the cycle after the strobe; `busy_o` goes to 1.
- R3: After k multiply steps (0 ≤ k ≤ 8), `prodrem_o` equals multiplicand × (multiplier mod 2^k) and `quot_o` equals multiplier shifted right by k.
- R4: `busy_o` stays 1 through the seventh multiply step and is 0 the cycle after the eighth; `prodrem_o` then holds the full 16-bit product.
- R5: A start-divide loads the dividend into `prodrem_o`, clears `quot_o`, and sets `busy_o` to 1.
- R6: After k divide steps (0 ≤ k ≤ 16), `quot_o` equals floor(dividend / (divisor·2^(16−k))) and `prodrem_o` equals dividend mod (divisor·2^(16−k)).
- R7: `busy_o` stays 1 through the fifteenth divide step and is 0 the cycle after the sixteenth; `quot_o` and `prodrem_o` then hold the full quotient and remainder.
- R8: A divide by zero ends with `quot_o` = 16'hFFFF and `prodrem_o` equal to the dividend; after k steps `quot_o` is 2^k − 1.
- R9: A cycle with `step_i` low and no start, or with `step_i` high while idle, leaves `prodrem_o`, `quot_o` and `busy_o` unchanged.
- R10: A start while busy discards the running operation and begins the new one. When both strobes are high together, the divide is started. A step in the same cycle as a start is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a_i | input | 8 | Multiplicand, or divisor for a divide |
| opnd_b_i | input | 8 | Multiplier |
| dividend_i | input | 16 | Dividend |
| start_mul_i | input | 1 | Start-multiply strobe, one cycle |
| start_div_i | input | 1 | Start-divide strobe, one cycle; wins over start-multiply |
| step_i | input | 1 | Step edge: one arithmetic step in each cycle it is high |
| busy_o | output | 1 | High while steps remain |
| prodrem_o | output | 16 | Product, or partial remainder |
| quot_o | output | 16 | Quotient, or the remaining multiplier bits |

## Verification
The checker infers the current operation from the last start strobe it saw. Its per-step properties therefore take for granted that operands are held stable only at the start cycle, and that every start is a single-cycle pulse. The bench drives each strobe for exactly one cycle. It changes inputs only on the falling edge, and it issues steps only after a start has been given. The one exception is the deliberate idle-step and overlap cases, where the checker's mode guards keep the per-step properties out of play.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int MW = 8,
    parameter int DW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_mul_i,
    input  logic start_div_i,
    input  logic step_i,
    output logic load_mul_o,
    output logic load_div_o,
    output logic mul_step_o,
    output logic div_step_o,
    output logic busy_o
);

    localparam int CW = $clog2(DW + 1);

    md_state_e        state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             any_start;

    assign any_start = start_mul_i | start_div_i;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (start_div_i) begin
            state_d = ST_DIV;
            cnt_d   = CW'(DW);
        end else if (start_mul_i) begin
            state_d = ST_MUL;
            cnt_d   = CW'(MW);
        end else if (step_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_MUL, ST_DIV: begin
                    cnt_d = cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) begin
                        state_d = ST_IDLE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        load_div_o = start_div_i;
        load_mul_o = start_mul_i & ~start_div_i;
        mul_step_o = 1'b0;
        div_step_o = 1'b0;
        busy_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_MUL: begin
                busy_o     = 1'b1;
                mul_step_o = step_i & ~any_start;
            end
            ST_DIV: begin
                busy_o     = 1'b1;
                div_step_o = step_i & ~any_start;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int MW = 8,
    parameter int DW = 16
) (
    input  logic [DW-1:0]    rem_i,
    input  logic [DW-1:0]    quot_i,
    input  logic [DW+MW-1:0] shf_i,
    output logic [DW-1:0]    mul_rem_o,
    output logic [DW-1:0]    mul_quot_o,
    output logic [DW+MW-1:0] mul_shf_o,
    output logic [DW-1:0]    div_rem_o,
    output logic [DW-1:0]    div_quot_o,
    output logic [DW+MW-1:0] div_shf_o
);

    localparam int SW = DW + MW;

    logic [SW-1:0] shf_half;
    logic          fits;

    // shift-and-add step
    always_comb begin
        mul_rem_o  = quot_i[0] ? (rem_i + shf_i[DW-1:0]) : rem_i;
        mul_quot_o = quot_i >> 1;
        mul_shf_o  = shf_i << 1;
    end

    // restoring divide step
    always_comb begin
        shf_half   = shf_i >> 1;
        fits       = {{MW{1'b0}}, rem_i} >= shf_half;
        div_shf_o  = shf_half;
        div_quot_o = {quot_i[DW-2:0], fits};
        div_rem_o  = fits ? (rem_i - shf_half[DW-1:0]) : rem_i;
    end

endmodule

// File: rtl/muldiv_regs.sv
module muldiv_regs #(
    parameter int MW = 8,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_mul_i,
    input  logic             load_div_i,
    input  logic             mul_step_i,
    input  logic             div_step_i,
    input  logic [MW-1:0]    opnd_a_i,
    input  logic [MW-1:0]    opnd_b_i,
    input  logic [DW-1:0]    dividend_i,
    input  logic [DW-1:0]    mul_rem_i,
    input  logic [DW-1:0]    mul_quot_i,
    input  logic [DW+MW-1:0] mul_shf_i,
    input  logic [DW-1:0]    div_rem_i,
    input  logic [DW-1:0]    div_quot_i,
    input  logic [DW+MW-1:0] div_shf_i,
    output logic [DW-1:0]    rem_o,
    output logic [DW-1:0]    quot_o,
    output logic [DW+MW-1:0] shf_o
);

    localparam int SW = DW + MW;

    logic [DW-1:0] rem_d, quot_d;
    logic [SW-1:0] shf_d;

    always_comb begin
        rem_d  = rem_o;
        quot_d = quot_o;
        shf_d  = shf_o;
        if (load_div_i) begin
            rem_d  = dividend_i;
            quot_d = '0;
            shf_d  = {opnd_a_i, {DW{1'b0}}};
        end else if (load_mul_i) begin
            rem_d  = '0;
            quot_d = {{(DW-MW){1'b0}}, opnd_b_i};
            shf_d  = {{DW{1'b0}}, opnd_a_i};
        end else if (mul_step_i) begin
            rem_d  = mul_rem_i;
            quot_d = mul_quot_i;
            shf_d  = mul_shf_i;
        end else if (div_step_i) begin
            rem_d  = div_rem_i;
            quot_d = div_quot_i;
            shf_d  = div_shf_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_o  <= '0;
            quot_o <= '0;
            shf_o  <= '0;
        end else begin
            rem_o  <= rem_d;
            quot_o <= quot_d;
            shf_o  <= shf_d;
        end
    end

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
    parameter int MW = 8,
    parameter int DW = 2 * MW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] opnd_a_i,
    input  logic [MW-1:0] opnd_b_i,
    input  logic [DW-1:0] dividend_i,
    input  logic          start_mul_i,
    input  logic          start_div_i,
    input  logic          step_i,
    output logic          busy_o,
    output logic [DW-1:0] prodrem_o,
    output logic [DW-1:0] quot_o
);

    localparam int SW = DW + MW;

    logic          load_mul, load_div, mul_step, div_step;
    logic [DW-1:0] rem_q, quot_q;
    logic [SW-1:0] shf_q;
    logic [DW-1:0] mul_rem, mul_quot, div_rem, div_quot;
    logic [SW-1:0] mul_shf, div_shf;

    muldiv_ctrl #(.MW(MW), .DW(DW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_mul_i (start_mul_i),
        .start_div_i (start_div_i),
        .step_i      (step_i),
        .load_mul_o  (load_mul),
        .load_div_o  (load_div),
        .mul_step_o  (mul_step),
        .div_step_o  (div_step),
        .busy_o      (busy_o)
    );

    muldiv_step #(.MW(MW), .DW(DW)) step_i_u (
        .rem_i      (rem_q),
        .quot_i     (quot_q),
        .shf_i      (shf_q),
        .mul_rem_o  (mul_rem),
        .mul_quot_o (mul_quot),
        .mul_shf_o  (mul_shf),
        .div_rem_o  (div_rem),
        .div_quot_o (div_quot),
        .div_shf_o  (div_shf)
    );

    muldiv_regs #(.MW(MW), .DW(DW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_mul_i (load_mul),
        .load_div_i (load_div),
        .mul_step_i (mul_step),
        .div_step_i (div_step),
        .opnd_a_i   (opnd_a_i),
        .opnd_b_i   (opnd_b_i),
        .dividend_i (dividend_i),
        .mul_rem_i  (mul_rem),
        .mul_quot_i (mul_quot),
        .mul_shf_i  (mul_shf),
        .div_rem_i  (div_rem),
        .div_quot_i (div_quot),
        .div_shf_i  (div_shf),
        .rem_o      (rem_q),
        .quot_o     (quot_q),
        .shf_o      (shf_q)
    );

    assign prodrem_o = rem_q;
    assign quot_o    = quot_q;

endmodule

// File: rtl/muldiv_iter_chk.sv
module muldiv_iter_chk #(
    parameter int MW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [MW-1:0] opnd_b_i,
    input logic [DW-1:0] dividend_i,
    input logic          start_mul_i,
    input logic          start_div_i,
    input logic          step_i,
    input logic          busy_o,
    input logic [DW-1:0] prodrem_o,
    input logic [DW-1:0] quot_o
);

    logic in_mul, in_div, quiet;

    assign quiet = ~start_mul_i & ~start_div_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_mul <= 1'b0;
            in_div <= 1'b0;
        end else if (start_div_i) begin
            in_mul <= 1'b0;
            in_div <= 1'b1;
        end else if (start_mul_i) begin
            in_mul <= 1'b1;
            in_div <= 1'b0;
        end
    end

    AST_MUL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_mul_i && !start_div_i) |=> (busy_o && prodrem_o == '0 &&
            quot_o == {{(DW-MW){1'b0}}, $past(opnd_b_i)})); // R2

    AST_MUL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mul && busy_o && step_i && quiet) |=>
            (quot_o == ($past(quot_o) >> 1) && prodrem_o >= $past(prodrem_o))); // R3

    AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_div_i |=> (busy_o && quot_o == '0 && prodrem_o == $past(dividend_i))); // R5

    AST_DIV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_div && busy_o && step_i && quiet) |=>
            (quot_o[DW-1:1] == $past(quot_o[DW-2:0]) && prodrem_o <= $past(prodrem_o))); // R6

    AST_BUSY_ENDS_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(step_i)); // R7

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && (!step_i || !busy_o)) |=>
            ($stable(prodrem_o) && $stable(quot_o) && $stable(busy_o))); // R9

    AST_START_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !quiet) |=> busy_o); // R10

endmodule

bind muldiv_iter muldiv_iter_chk #(.MW(MW), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .opnd_b_i    (opnd_b_i),
    .dividend_i  (dividend_i),
    .start_mul_i (start_mul_i),
    .start_div_i (start_div_i),
    .step_i      (step_i),
    .busy_o      (busy_o),
    .prodrem_o   (prodrem_o),
    .quot_o      (quot_o)
);

// File: tb/muldiv_iter_tb.sv
`timescale 1ns/1ps
module muldiv_iter_tb_top;

    localparam int MW = 8;
    localparam int DW = 16;
    localparam int NV = 8;
    localparam int VW = 1 + MW + MW + DW + DW + DW;

    // {is_div, opnd_a, opnd_b, dividend, expected prodrem, expected quot}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 8'd13,  8'd11,  16'd0,     16'd143,   16'd0},
        {1'b0, 8'd255, 8'd255, 16'd0,     16'd65025, 16'd0},
        {1'b0, 8'd0,   8'd200, 16'd0,     16'd0,     16'd0},
        {1'b0, 8'd1,   8'd128, 16'd0,     16'd128,   16'd0},
        {1'b1, 8'd7,   8'd0,   16'd1000,  16'd6,     16'd142},
        {1'b1, 8'd255, 8'd0,   16'd65535, 16'd0,     16'd257},
        {1'b1, 8'd9,   8'd0,   16'd5,     16'd5,     16'd0},
        {1'b1, 8'd1,   8'd0,   16'd40000, 16'd0,     16'd40000}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [MW-1:0] opnd_a, opnd_b;
    logic [DW-1:0] dividend;
    logic          start_mul, start_div, step;
    logic          busy;
    logic [DW-1:0] prodrem, quot;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    muldiv_iter #(.MW(MW), .DW(DW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .opnd_a_i    (opnd_a),
        .opnd_b_i    (opnd_b),
        .dividend_i  (dividend),
        .start_mul_i (start_mul),
        .start_div_i (start_div),
        .step_i      (step),
        .busy_o      (busy),
        .prodrem_o   (prodrem),
        .quot_o      (quot)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // entered and left at a falling edge
    task automatic start_op(input logic m, input logic d, input logic [MW-1:0] a,
                            input logic [MW-1:0] b, input logic [DW-1:0] n, input logic stp);
        opnd_a = a; opnd_b = b; dividend = n;
        start_mul = m; start_div = d; step = stp;
        @(posedge clk);
        @(negedge clk);
        start_mul = 1'b0; start_div = 1'b0; step = 1'b0;
    endtask

    task automatic do_step();
        step = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) do_step();
    endtask

    initial begin
        #1ms;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        longint a, b, n, d, mk;
        rst_n = 1'b0; opnd_a = '0; opnd_b = '0; dividend = '0;
        start_mul = 1'b0; start_div = 1'b0; step = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 prodrem", prodrem, 0);
        check("R1 quot", quot, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic          isd;
            logic [MW-1:0] va, vb;
            logic [DW-1:0] vn, epr, eq;
            {isd, va, vb, vn, epr, eq} = VEC[v];
            start_op(~isd, isd, va, vb, vn, 1'b0);
            if (isd) begin
                check("R5 load rem", prodrem, vn);
                check("R5 busy", busy, 1);
                steps(DW);
                check("R7 quot", quot, eq);
                check("R7 rem", prodrem, epr);
                check("R7 busy", busy, 0);
            end else begin
                check("R2 load quot", quot, vb);
                check("R2 load prod", prodrem, 0);
                steps(MW);
                check("R4 product", prodrem, epr);
                check("R4 quot", quot, eq);
                check("R4 busy", busy, 0);
            end
        end

        // R9: step while idle changes nothing (last result 40000/1)
        steps(3);
        check("R9 idle quot", quot, 40000);
        check("R9 idle rem", prodrem, 0);
        check("R9 idle busy", busy, 0);

        // R3 partial multiply, R4 busy timing, R9 hold without step
        a = 183; b = 109;
        start_op(1'b1, 1'b0, 8'(a), 8'(b), 16'd0, 1'b0);
        repeat (5) @(negedge clk);
        check("R9 hold prod", prodrem, 0);
        check("R9 hold quot", quot, b);
        check("R9 hold busy", busy, 1);
        for (int k = 1; k <= MW; k++) begin
            do_step();
            mk = (longint'(1) << k) - 1;
            check("R3 partial prod", prodrem, (a * (b & mk)) & 16'hFFFF);
            check("R3 partial quot", quot, b >> k);
            if (k == MW - 1) check("R4 busy at 7", busy, 1);
        end
        check("R4 busy done", busy, 0);

        // R6 partial divide, R7 busy timing
        n = 50000; d = 37;
        start_op(1'b0, 1'b1, 8'(d), 8'd0, 16'(n), 1'b0);
        for (int k = 1; k <= DW; k++) begin
            do_step();
            check("R6 partial quot", quot, n / (d << (DW - k)));
            check("R6 partial rem", prodrem, n % (d << (DW - k)));
            if (k == DW - 1) check("R7 busy at 15", busy, 1);
        end
        check("R7 busy done", busy, 0);

        // R8 divide by zero
        n = 1234;
        start_op(1'b0, 1'b1, 8'd0, 8'd0, 16'(n), 1'b0);
        for (int k = 1; k <= DW; k++) begin
            do_step();
            check("R8 partial quot", quot, (longint'(1) << k) - 1);
        end
        check("R8 quot", quot, 16'hFFFF);
        check("R8 rem", prodrem, n);

        // R10 restart mid-multiply with a divide, step in start cycle ignored
        start_op(1'b1, 1'b0, 8'd200, 8'd77, 16'd0, 1'b0);
        steps(3);
        start_op(1'b0, 1'b1, 8'd13, 8'd0, 16'd999, 1'b1);
        check("R10 override rem", prodrem, 999);
        check("R10 override quot", quot, 0);
        steps(DW - 1);
        check("R10 step not counted busy", busy, 1);
        do_step();
        check("R10 override busy", busy, 0);
        check("R10 override quot", quot, 999 / 13);
        check("R10 override rem", prodrem, 999 % 13);

        // R10 both strobes: divide wins
        start_op(1'b1, 1'b1, 8'd5, 8'd3, 16'd100, 1'b0);
        check("R10 both rem", prodrem, 100);
        check("R10 both quot", quot, 0);
        steps(DW);
        check("R10 both result", quot, 20);
        check("R10 both busy", busy, 0);

        finish_run();
    end

endmodule